// File: doc/BRIEF.md
# Vectored Interrupt Controller with Latched NMI Source

This block collects up to 96 interrupt request lines, grouped into three 32-bit banks, and presents them to a processor as one interrupt line plus a vector register that names the source to service. Source n belongs to bank n/32 at bit position n%32. Every line except source 0 is level-sensitive: its pending bit is a registered copy of the input. Source 0 is the external non-maskable input. A configurable trigger condition captures it, and it stays pending until software clears it.

A request reaches the processor only when its enable bit is set and its mask bit is clear. The controller picks the lowest-numbered request that passes this gate. It reports that source number, shifted left by two, in the vector register. Because the vector reads zero both when source 0 is selected and when nothing is active, software reads the pending bit of source 0 to tell the two cases apart. A parameter moves the enable and mask registers to a compact alternate layout. Access is through a plain 32-bit register bus with single-cycle write and read strobes and a registered read-data path.

Top module: `intc_vector_ctrl`

## Requirements
- R1: After reset, every enable, mask and pending bit is 0, the protection and trigger-type registers read 0, `irq_o` is 0 and the vector reads 0, provided source 0 is held high.
- R2: For each source n ≥ 1, the bit n%32 of the pending register of bank n/32 equals the input sampled at the previous clock edge. A write-one-to-clear to such a bit has no lasting effect while the input stays high.
- R3: Source 0's pending bit (bank 0, bit 0) stays set after its trigger condition goes away. It is cleared only by writing 1 to bit 0 at offset 0x10. If the trigger condition holds in the same cycle as the clear, the bit stays set.
- R4: The trigger-type register at offset 0x0C stores bits [1:0] and reads 0 elsewhere. Its codes are 0 = low level, 1 = high level, 2 = falling edge and 3 = rising edge of source 0.
- R5: A pending source is active only when its enable bit is 1 and its mask bit is 0.
- R6: `irq_o` is the registered OR of all active sources. It rises two clock edges after a level source input rises.
- R7: A read of offset 0x00 returns the number of the lowest-numbered active source in bits [8:2], with all other bits 0. It reads 0 when no source is active.
- R8: When source 0 is active, the vector reads 0 while `irq_o` is 1 and bit 0 of pending bank 0 reads 1.
- R9: In the default layout, pending banks sit at 0x10/0x14/0x18, fast status at 0x20/0x24/0x28, enable at 0x40/0x44/0x48 and mask at 0x50/0x54/0x58. Enable and mask read back what was written.
- R10: With the alternate layout parameter set, enable sits at 0x20/0x24/0x28 and mask at 0x30/0x34/0x38, and offset 0x40 reads 0.
- R11: The fast status register of a bank reads the bits that are pending, enabled and masked.
- R12: The protection register at 0x08 stores bit 0 only, reads 0 in all other bits, and does not change `irq_o`.
- R13: Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`. Unmapped or unaligned offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| src_i | input | NBANK*DATA_W | Interrupt request lines; bit 0 is the non-maskable source |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest case to reach is source 0 holding its pending bit while its line is quiet. Edge-sensitive capture means the line must be steered through a full transition after the trigger type is changed, with stale captures cleared first. The stimulus switches the trigger type, clears the pending bit, and only then drives the edge or level under test. It then releases the line and confirms that the bit, the zero vector and the raised output all persist. A further case checks a clear issued while a level trigger is still asserted, and another confirms a pending source 0 outranks a level source.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  localparam logic [7:0] OFS_VEC    = 8'h00;
  localparam logic [7:0] OFS_PROT   = 8'h08;
  localparam logic [7:0] OFS_TRIG   = 8'h0C;
  localparam logic [7:0] OFS_PEND   = 8'h10;
  localparam logic [7:0] OFS_FAST   = 8'h20;
  localparam logic [7:0] OFS_EN_STD = 8'h40;
  localparam logic [7:0] OFS_MK_STD = 8'h50;
  localparam logic [7:0] OFS_EN_ALT = 8'h20;
  localparam logic [7:0] OFS_MK_ALT = 8'h30;
endpackage

// File: rtl/intc_nmi_latch.sv
module intc_nmi_latch
  import intc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  line_i,
  input  trig_e mode_i,
  input  logic  clr_i,
  output logic  pend_o
);
  logic line_q;
  logic fire;

  always_comb begin
    unique case (mode_i)
      TRIG_LOW:  fire = ~line_i;
      TRIG_HIGH: fire = line_i;
      TRIG_FALL: fire = line_q & ~line_i;
      TRIG_RISE: fire = ~line_q & line_i;
      default:   fire = 1'b0;
    endcase
  end

  // a capture in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      line_q <= line_i;
      pend_o <= fire | (pend_o & ~clr_i);
    end
  end
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int N     = 96,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     act_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [IDX_W-1:0] idx_d;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    idx_d = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) idx_d = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_o <= '0;
      any_o <= 1'b0;
    end else begin
      idx_o <= idx_d;
      any_o <= |act_i;
    end
  end
endmodule

// File: rtl/intc_vector_ctrl.sv
module intc_vector_ctrl
  import intc_pkg::*;
#(
  parameter int NBANK   = 3,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter bit ALT_MAP = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NBANK*DATA_W-1:0] src_i,
  output logic                    irq_o
);
  localparam int NSRC  = NBANK * DATA_W;
  localparam int IDX_W = $clog2(NSRC);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(OFS_VEC);
  localparam logic [ADDR_W-1:0] A_PROT = ADDR_W'(OFS_PROT);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_FAST = ADDR_W'(OFS_FAST);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ALT_MAP ? OFS_EN_ALT : OFS_EN_STD);
  localparam logic [ADDR_W-1:0] A_MK   = ADDR_W'(ALT_MAP ? OFS_MK_ALT : OFS_MK_STD);

  logic [DATA_W-1:0] en_q  [NBANK];
  logic [DATA_W-1:0] msk_q [NBANK];
  logic [NSRC-1:0]   en_all, msk_all, pend_all, act_all;
  logic [NSRC-1:1]   lvl_q;
  logic              nmi_pend, nmi_clr;
  logic              prot_q;
  trig_e             trig_q;
  logic [IDX_W-1:0]  vec_idx;
  logic [DATA_W-1:0] rd_mux;

  // address decode
  logic       word_ok, wr_ok;
  logic [1:0] bank_idx;
  logic       hit_vec, hit_prot, hit_trig, hit_pend, hit_en, hit_mk, hit_fast;

  assign word_ok  = (bus_addr[1:0] == 2'b00);
  assign wr_ok    = bus_wr & word_ok;
  assign bank_idx = bus_addr[3:2];
  assign hit_vec  = (bus_addr == A_VEC);
  assign hit_prot = (bus_addr == A_PROT);
  assign hit_trig = (bus_addr == A_TRIG);
  assign hit_pend = (bus_addr[ADDR_W-1:4] == A_PEND[ADDR_W-1:4]);
  assign hit_en   = (bus_addr[ADDR_W-1:4] == A_EN[ADDR_W-1:4]);
  assign hit_mk   = (bus_addr[ADDR_W-1:4] == A_MK[ADDR_W-1:4]);
  assign hit_fast = !ALT_MAP && (bus_addr[ADDR_W-1:4] == A_FAST[ADDR_W-1:4]);

  // per-bank enable and mask storage
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[b]  <= '0;
        msk_q[b] <= '0;
      end else if (wr_ok && bank_idx == 2'(b)) begin
        if (hit_en)      en_q[b]  <= bus_wdata;
        else if (hit_mk) msk_q[b] <= bus_wdata;
      end
    end
    assign en_all[b*DATA_W +: DATA_W]  = en_q[b];
    assign msk_all[b*DATA_W +: DATA_W] = msk_q[b];
  end

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q <= 1'b0;
      trig_q <= TRIG_LOW;
    end else if (wr_ok) begin
      if (hit_prot) prot_q <= bus_wdata[0];
      if (hit_trig) trig_q <= trig_e'(bus_wdata[1:0]);
    end
  end

  // level sources: pending is the sampled input
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= src_i[NSRC-1:1];
  end

  assign nmi_clr = wr_ok & hit_pend & (bank_idx == 2'd0) & bus_wdata[0];

  intc_nmi_latch u_nmi (
    .clk    (clk),
    .rst    (rst),
    .line_i (src_i[0]),
    .mode_i (trig_q),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pend)
  );

  assign pend_all = {lvl_q, nmi_pend};
  assign act_all  = pend_all & en_all & ~msk_all;

  intc_prio_enc #(.N(NSRC), .IDX_W(IDX_W)) u_enc (
    .clk   (clk),
    .rst   (rst),
    .act_i (act_all),
    .idx_o (vec_idx),
    .any_o (irq_o)
  );

  // read path
  always_comb begin
    rd_mux = '0;
    if (word_ok) begin
      if (hit_vec)       rd_mux = DATA_W'({vec_idx, 2'b00});
      else if (hit_prot) rd_mux = DATA_W'(prot_q);
      else if (hit_trig) rd_mux = DATA_W'(trig_q);
      else begin
        for (int b = 0; b < NBANK; b++) begin
          if (bank_idx == 2'(b)) begin
            if (hit_pend)      rd_mux = pend_all[b*DATA_W +: DATA_W];
            else if (hit_en)   rd_mux = en_q[b];
            else if (hit_mk)   rd_mux = msk_q[b];
            else if (hit_fast) rd_mux = pend_all[b*DATA_W +: DATA_W] & en_q[b] & msk_q[b];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/intc_vector_chk.sv
module intc_vector_chk #(
  parameter int N     = 96,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     src,
  input logic [N-1:0]     pend,
  input logic [N-1:0]     act,
  input logic             clr0,
  input logic             irq,
  input logic [IDX_W-1:0] vec
);
  logic         past_ok;
  logic [N-1:0] act_q;
  logic [N-1:0] below;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      act_q   <= '0;
    end else begin
      past_ok <= 1'b1;
      act_q   <= act;
    end
  end

  assign below = (N'(1) << vec) - N'(1);

  a_r2_level_follow: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> pend[N-1:1] == $past(src[N-1:1]));

  a_r3_nmi_hold: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(pend[0]) && !$past(clr0)) |-> pend[0]);

  a_r6_irq_or: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> irq == (|act_q));

  a_r7_vec_lowest: assert property (@(posedge clk) disable iff (rst)
    (past_ok && irq) |-> (act_q[vec] && ((act_q & below) == '0)));

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !irq |-> vec == '0);
endmodule

bind intc_vector_ctrl intc_vector_chk #(.N(NSRC), .IDX_W(IDX_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .src  (src_i),
  .pend (pend_all),
  .act  (act_all),
  .clr0 (nmi_clr),
  .irq  (irq_o),
  .vec  (vec_idx)
);

// File: tb/sim_intc_vector_ctrl.sv
`timescale 1ns/1ps
module sim_intc_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr0 = 1'b0, wr1 = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [95:0] src = 96'd1;
  logic        irq0, irq1;
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  intc_vector_ctrl u0 (
    .clk(clk), .rst(rst), .bus_wr(wr0), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata0), .src_i(src), .irq_o(irq0));

  intc_vector_ctrl #(.ALT_MAP(1'b1)) u1 (
    .clk(clk), .rst(rst), .bus_wr(wr1), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata1), .src_i(src), .irq_o(irq1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit alt, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (alt) wr1 = 1'b1; else wr0 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rdreg(input bit alt, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = alt ? rdata1 : rdata0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    logic [31:0] v;
    waitc(4);
    rst = 1'b0;
    waitc(2);

    // R1 reset state
    for (int b = 0; b < 3; b++) begin
      rdreg(0, 8'h40 + 8'(4*b), v); chk("R1 enable", v, 0);
      rdreg(0, 8'h50 + 8'(4*b), v); chk("R1 mask", v, 0);
      rdreg(0, 8'h10 + 8'(4*b), v); chk("R1 pending", v, 0);
    end
    rdreg(0, 8'h08, v); chk("R1 protect", v, 0);
    rdreg(0, 8'h0C, v); chk("R1 trigger", v, 0);
    rdreg(0, 8'h00, v); chk("R1 vector", v, 0);
    chk("R1 irq", 32'(irq0), 0);

    // R9 enable/mask read back, R13 unmapped and unaligned
    wr(0, 8'h44, 32'hA5A5_0F0F); rdreg(0, 8'h44, v); chk("R9 enable bank1", v, 32'hA5A5_0F0F);
    wr(0, 8'h58, 32'h1234_5678); rdreg(0, 8'h58, v); chk("R9 mask bank2", v, 32'h1234_5678);
    wr(0, 8'h04, 32'hFFFF_FFFF); rdreg(0, 8'h04, v); chk("R13 unmapped", v, 0);
    wr(0, 8'h41, 32'h0);         rdreg(0, 8'h44, v); chk("R13 unaligned write ignored", v, 32'hA5A5_0F0F);
    rdreg(0, 8'h45, v); chk("R13 unaligned read", v, 0);

    for (int b = 0; b < 3; b++) begin
      wr(0, 8'h40 + 8'(4*b), 32'hFFFF_FFFF);
      wr(0, 8'h50 + 8'(4*b), 32'h0);
    end

    // R6 output latency
    @(negedge clk); src = 96'd1; src[33] = 1'b1;
    @(posedge clk); #1 chk("R6 irq after one edge", 32'(irq0), 0);
    @(posedge clk); #1 chk("R6 irq after two edges", 32'(irq0), 1);

    // R7/R2 sweep of every level source
    for (int n = 1; n < 96; n++) begin
      @(negedge clk); src = 96'd1; src[n] = 1'b1;
      waitc(3);
      rdreg(0, 8'h00, v); chk("R7 vector single", v, 32'(n) << 2);
      chk("R6 irq single", 32'(irq0), 1);
      rdreg(0, 8'h10 + 8'(4*(n/32)), v); chk("R2 pending position", v, 32'd1 << (n % 32));
    end

    // R7 lowest wins
    for (int n = 1; n < 94; n += 4) begin
      @(negedge clk); src = 96'd1; src[n] = 1'b1; src[n+2] = 1'b1; src[95] = 1'b1;
      waitc(3);
      rdreg(0, 8'h00, v); chk("R7 lowest of several", v, 32'(n) << 2);
    end

    // R2 clear has no lasting effect on a high level source; release drops it
    @(negedge clk); src = 96'd1; src[5] = 1'b1;
    waitc(2);
    wr(0, 8'h10, 32'h20); waitc(1);
    rdreg(0, 8'h10, v); chk("R2 w1c on level", v, 32'h20);
    @(negedge clk); src[5] = 1'b0; waitc(2);
    rdreg(0, 8'h10, v); chk("R2 level release", v, 0);

    // R5 gating, R11 fast status
    @(negedge clk); src = 96'd1; src[10] = 1'b1; src[40] = 1'b1;
    wr(0, 8'h50, 32'h400); waitc(3);
    rdreg(0, 8'h00, v); chk("R5 masked source skipped", v, 32'd40 << 2);
    rdreg(0, 8'h20, v); chk("R11 fast status", v, 32'h400);
    rdreg(0, 8'h24, v); chk("R11 fast status bank1", v, 0);
    wr(0, 8'h44, 32'hFFFF_FEFF); waitc(3);
    chk("R5 disabled source blocks irq", 32'(irq0), 0);
    rdreg(0, 8'h00, v); chk("R7 idle vector", v, 0);

    // R12 protection register
    wr(0, 8'h08, 32'hFFFF_FFFF); rdreg(0, 8'h08, v); chk("R12 protect bit", v, 1);
    chk("R12 irq unaffected", 32'(irq0), 0);

    // R4 trigger register
    wr(0, 8'h0C, 32'hFF); rdreg(0, 8'h0C, v); chk("R4 trigger field", v, 3);

    wr(0, 8'h50, 32'h0); wr(0, 8'h44, 32'hFFFF_FFFF);
    @(negedge clk); src = 96'd1;

    // R3/R4/R8 rising edge (trigger code 3 already set)
    wr(0, 8'h10, 32'h1); waitc(1);
    @(negedge clk); src[0] = 1'b0; waitc(2);
    rdreg(0, 8'h10, v); chk("R4 rising ignores fall", v, 0);
    @(negedge clk); src[0] = 1'b1; waitc(1);
    @(negedge clk); src[0] = 1'b0; waitc(3);
    rdreg(0, 8'h10, v); chk("R3 latched after line drops", v, 1);
    rdreg(0, 8'h00, v); chk("R8 vector zero for source 0", v, 0);
    chk("R8 irq for source 0", 32'(irq0), 1);
    @(negedge clk); src[7] = 1'b1; waitc(3);
    rdreg(0, 8'h00, v); chk("R7 source 0 outranks 7", v, 0);
    wr(0, 8'h10, 32'h1); waitc(3);
    rdreg(0, 8'h00, v); chk("R3 cleared, next source", v, 32'd7 << 2);
    rdreg(0, 8'h10, v); chk("R3 cleared pending", v, 32'h80);
    @(negedge clk); src[7] = 1'b0;

    // falling edge
    wr(0, 8'h0C, 32'd2);
    @(negedge clk); src[0] = 1'b1; waitc(2);
    wr(0, 8'h10, 32'h1); waitc(2);
    rdreg(0, 8'h10, v); chk("R4 falling idle", v, 0);
    @(negedge clk); src[0] = 1'b0; waitc(3);
    rdreg(0, 8'h10, v); chk("R4 falling captured", v, 1);
    wr(0, 8'h10, 32'h1); waitc(3);
    rdreg(0, 8'h10, v); chk("R4 falling no retrigger", v, 0);

    // high level, clear while asserted
    wr(0, 8'h0C, 32'd1); wr(0, 8'h10, 32'h1); waitc(2);
    rdreg(0, 8'h10, v); chk("R4 high idle", v, 0);
    @(negedge clk); src[0] = 1'b1; waitc(3);
    rdreg(0, 8'h10, v); chk("R4 high captured", v, 1);
    wr(0, 8'h10, 32'h1); waitc(2);
    rdreg(0, 8'h10, v); chk("R3 set wins over clear", v, 1);
    @(negedge clk); src[0] = 1'b0; waitc(1);
    wr(0, 8'h10, 32'h1); waitc(2);
    rdreg(0, 8'h10, v); chk("R3 clear after release", v, 0);

    // low level
    wr(0, 8'h0C, 32'd0); waitc(2);
    rdreg(0, 8'h10, v); chk("R4 low captured", v, 1);
    @(negedge clk); src[0] = 1'b1; waitc(1);
    wr(0, 8'h10, 32'h1); waitc(3);
    rdreg(0, 8'h10, v); chk("R4 low cleared", v, 0);
    chk("R3 irq drops after clear", 32'(irq0), 0);

    // R10 alternate layout
    wr(1, 8'h20, 32'h8); rdreg(1, 8'h20, v); chk("R10 alt enable", v, 32'h8);
    rdreg(1, 8'h40, v); chk("R10 alt old enable offset", v, 0);
    @(negedge clk); src[3] = 1'b1; waitc(3);
    rdreg(1, 8'h00, v); chk("R10 alt vector", v, 32'd3 << 2);
    chk("R10 alt irq", 32'(irq1), 1);
    wr(1, 8'h30, 32'h8); waitc(3);
    chk("R10 alt mask", 32'(irq1), 0);
    rdreg(1, 8'h30, v); chk("R10 alt mask read", v, 32'h8);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule